// File: doc/BRIEF.md
# Dual Multiplier Stage with Pre-Adder

This block is a fully registered fixed-point multiply stage with a top and a bottom multiplier. A static mode parameter selects how the two products reach the outputs: two independent products, a sum or difference of both products, the top product plus a 36-bit addend built from the bottom data inputs, or one wide 27x27 product. Each operand's signedness is set by its own parameter.

Two options reshape the operands. A pre-adder adds or subtracts a z input to the y input of each multiplier before multiplication, using one operation for both multipliers. A constant bank holds eight fixed coefficients per multiplier; a 3-bit select then picks the x operand in place of the x data input.

Inputs pass through one register rank cleared by `aclr_in` and the outputs through a second rank cleared by `aclr_out`. Both ranks load only while `ena` is high, so a sample reaches the outputs after two enabled clock edges.

Top module: `dual_mult_preadd`

## Requirements
- R1: In dual mode, `resulta` is the full signed-extended product of the top operands and `resultb` is the low 37 bits of the bottom product.
- R2: In sum mode, `resulta` is bottom product plus top product when the registered `sub` is 0 and bottom product minus top product when it is 1; `resultb` is zero.
- R3: In plus-36 mode, `resulta` is the top product plus the 36-bit addend `{bx[17:0], by[17:0]}`, which is sign-extended when `bx` is declared signed; `resultb` is zero.
- R4: In wide mode, `resulta` is the product of the 27-bit `ax` and 27-bit `ay` fields; the bottom inputs have no effect and `resultb` is zero.
- R5: In the 18-bit modes each x operand is bits [17:0]; a signed y operand is bits [18:0] and an unsigned one is bits [17:0] with bit 18 ignored; signed operands are sign-extended, unsigned ones zero-extended.
- R6: With the pre-adder on, the y operand of each multiplier is y plus z, or y minus z when subtraction is chosen, over 18-bit fields in the 18-bit modes and 26-bit fields in wide mode, extended by the y signedness.
- R7: With the constant bank on, the x operand is the constant whose index equals the registered select (0 picks entry 0); the `ax`/`bx` inputs have no effect.
- R8: Inputs captured at one enabled edge appear on the outputs after the next enabled edge.
- R9: While `ena` is low both register ranks hold their contents.
- R10: `aclr_in` and `aclr_out` are asynchronous active-high clears of the input and output ranks; outputs are zero while `aclr_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both register ranks |
| ena | input | 1 | Clock enable for both ranks |
| aclr_in | input | 1 | Asynchronous clear of the input rank |
| aclr_out | input | 1 | Asynchronous clear of the output rank |
| ax | input | AX_W | Top multiplier x data |
| ay | input | AY_W | Top multiplier y data, pre-adder first term |
| az | input | AZ_W | Top pre-adder second term |
| bx | input | BX_W | Bottom x data, upper half of the 36-bit addend |
| by | input | BY_W | Bottom y data, lower half of the 36-bit addend |
| bz | input | BZ_W | Bottom pre-adder second term |
| sub | input | 1 | Sum mode: 1 subtracts the top product |
| coefsela | input | log2(COEF_N) | Constant index for the top x operand |
| coefselb | input | log2(COEF_N) | Constant index for the bottom x operand |
| resulta | output | RA_W | Main result |
| resultb | output | RB_W | Bottom product in dual mode, else zero |

## Verification
The bench targets the most negative operand codes, where a design that zero-extends a signed field or sign-extends an unsigned one returns a product off by a power of two, and an unsigned y with bit 18 set, which a design reading 19 bits would treat as a large value. It flips `sub` against identical data, so a swapped operand order shows as a wrong sign, and it changes `ax` while the constant bank is active, which a leaky x path would reflect. Enable stalls and clear pulses mid-stream expose a rank that loads while stalled, loses its contents, or clears only at a clock edge; a one-rank pipeline shows results a cycle early.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

   typedef enum logic [1:0] {
      DMP_DUAL   = 2'd0,
      DMP_SUM2   = 2'd1,
      DMP_PLUS36 = 2'd2,
      DMP_WIDE   = 2'd3
   } dmp_mode_e;

   localparam int PROD_W      = 64;
   localparam int IDX_W       = $clog2(PROD_W);
   localparam int NARROW_X    = 18;
   localparam int NARROW_YS   = 19;
   localparam int NARROW_YU   = 18;
   localparam int NARROW_PRE  = 18;
   localparam int WIDE_X      = 27;
   localparam int WIDE_Y      = 27;
   localparam int WIDE_PRE    = 26;
   localparam int ADDEND_HALF = 18;
   localparam int ADDEND_W    = 2 * ADDEND_HALF;

   // Extend the low w bits of v to PROD_W, by sign when s is set.
   function automatic logic signed [PROD_W-1:0] dmp_ext(input logic [PROD_W-1:0] v,
                                                         input int w, input bit s);
      logic [PROD_W-1:0] mask;
      logic [PROD_W-1:0] res;
      mask = (PROD_W'(1) << w) - PROD_W'(1);
      res  = v & mask;
      if (s && v[IDX_W'(w - 1)]) res = res | ~mask;
      return $signed(res);
   endfunction

endpackage

// File: rtl/dmp_reg.sv
module dmp_reg #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      if (W < 1) $error("dmp_reg: W must be at least 1");
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr)     q <= '0;
      else if (en) q <= d;
   end

   // R9: a stalled rank keeps its value
   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (clr)
      !en |=> $stable(q));

   // R10: the clear holds the rank at zero
   a_r10_clear_zero: assert property (@(posedge clk)
      clr |-> (q == '0));

endmodule

// File: rtl/dmp_lane.sv
module dmp_lane
   import dmp_pkg::*;
#(
   parameter int X_W      = 18,
   parameter int Y_W      = 19,
   parameter int Z_W      = 18,
   parameter int XF       = 18,
   parameter int YF       = 19,
   parameter int PF       = 18,
   parameter bit X_SIGNED = 1'b1,
   parameter bit Y_SIGNED = 1'b1,
   parameter bit PRE_EN   = 1'b0,
   parameter bit PRE_SUB  = 1'b0,
   parameter bit COEF_EN  = 1'b0,
   parameter int COEF_N   = 8,
   parameter int COEF_W   = 18,
   parameter logic [COEF_N*COEF_W-1:0] COEF = '0,
   localparam int SEL_W   = $clog2(COEF_N)
) (
   input  logic [X_W-1:0]           x_q,
   input  logic [Y_W-1:0]           y_q,
   input  logic [Z_W-1:0]           z_q,
   input  logic [SEL_W-1:0]         sel_q,
   output logic signed [PROD_W-1:0] x_eff,
   output logic signed [PROD_W-1:0] y_eff,
   output logic signed [PROD_W-1:0] prod
);

   initial begin
      if (!COEF_EN && X_W < XF) $error("dmp_lane: x port narrower than its field");
      if (COEF_EN && COEF_W < XF) $error("dmp_lane: constants narrower than x field");
      if (!PRE_EN && Y_W < YF) $error("dmp_lane: y port narrower than its field");
      if (PRE_EN && (Y_W < PF || Z_W < PF)) $error("dmp_lane: pre-adder field too wide");
      if (COEF_N < 2) $error("dmp_lane: constant bank needs two entries or more");
   end

   logic [XF-1:0] x_fld;

   // x source: constant bank or registered data
   generate
      if (COEF_EN) begin : g_coef
         logic [COEF_W-1:0] coef_word;
         always_comb coef_word = COEF[32'(sel_q)*COEF_W +: COEF_W];
         assign x_fld = coef_word[XF-1:0];
      end else begin : g_data
         assign x_fld = x_q[XF-1:0];
      end
   endgenerate

   assign x_eff = dmp_ext(PROD_W'(x_fld), XF, X_SIGNED);

   // y source: pre-adder or direct field
   generate
      if (PRE_EN) begin : g_pre
         logic signed [PROD_W-1:0] term_y;
         logic signed [PROD_W-1:0] term_z;
         assign term_y = dmp_ext(PROD_W'(y_q[PF-1:0]), PF, Y_SIGNED);
         assign term_z = dmp_ext(PROD_W'(z_q[PF-1:0]), PF, Y_SIGNED);
         if (PRE_SUB) begin : g_minus
            assign y_eff = term_y - term_z;
         end else begin : g_plus
            assign y_eff = term_y + term_z;
         end
      end else begin : g_direct
         assign y_eff = dmp_ext(PROD_W'(y_q[YF-1:0]), YF, Y_SIGNED);
      end
   endgenerate

   assign prod = x_eff * y_eff;

   logic unused_lane;
   assign unused_lane = ^{x_q, y_q, z_q, sel_q};

endmodule

// File: rtl/dmp_combine.sv
module dmp_combine
   import dmp_pkg::*;
#(
   parameter dmp_mode_e MODE      = DMP_DUAL,
   parameter int        RA_W      = 64,
   parameter int        RB_W      = 37,
   parameter bit        BX_SIGNED = 1'b1
) (
   input  logic signed [PROD_W-1:0] prod_a,
   input  logic signed [PROD_W-1:0] prod_b,
   input  logic                     sub_q,
   input  logic [ADDEND_HALF-1:0]   addend_hi,
   input  logic [ADDEND_HALF-1:0]   addend_lo,
   output logic [RA_W-1:0]          res_a_d,
   output logic [RB_W-1:0]          res_b_d
);

   initial begin
      if (RA_W > PROD_W || RA_W < 1) $error("dmp_combine: RA_W out of range");
      if (RB_W > PROD_W || RB_W < 1) $error("dmp_combine: RB_W out of range");
   end

   logic signed [PROD_W-1:0] sum_a;

   generate
      if (MODE == DMP_DUAL) begin : g_dual
         assign sum_a   = prod_a;
         assign res_b_d = prod_b[RB_W-1:0];
      end else if (MODE == DMP_SUM2) begin : g_sum2
         always_comb begin
            if (sub_q) sum_a = prod_b - prod_a;
            else       sum_a = prod_b + prod_a;
         end
         assign res_b_d = '0;
      end else if (MODE == DMP_PLUS36) begin : g_plus36
         logic signed [PROD_W-1:0] addend;
         assign addend  = dmp_ext(PROD_W'({addend_hi, addend_lo}), ADDEND_W, BX_SIGNED);
         assign sum_a   = prod_a + addend;
         assign res_b_d = '0;
      end else begin : g_wide
         assign sum_a   = prod_a;
         assign res_b_d = '0;
      end
   endgenerate

   assign res_a_d = sum_a[RA_W-1:0];

   logic unused_comb;
   assign unused_comb = ^{prod_b, sub_q, addend_hi, addend_lo, sum_a};

endmodule

// File: rtl/dual_mult_preadd.sv
module dual_mult_preadd
   import dmp_pkg::*;
#(
   parameter dmp_mode_e MODE      = DMP_DUAL,
   parameter int        AX_W      = 27,
   parameter int        AY_W      = 27,
   parameter int        AZ_W      = 26,
   parameter int        BX_W      = 18,
   parameter int        BY_W      = 19,
   parameter int        BZ_W      = 18,
   parameter int        RA_W      = 64,
   parameter int        RB_W      = 37,
   parameter bit        AX_SIGNED = 1'b1,
   parameter bit        AY_SIGNED = 1'b1,
   parameter bit        BX_SIGNED = 1'b1,
   parameter bit        BY_SIGNED = 1'b1,
   parameter bit        PRE_EN    = 1'b0,
   parameter bit        PRE_SUB   = 1'b0,
   parameter bit        COEF_EN   = 1'b0,
   parameter int        COEF_N    = 8,
   parameter int        COEF_A_W  = 27,
   parameter int        COEF_B_W  = 18,
   parameter logic [COEF_N*COEF_A_W-1:0] COEF_A = '0,
   parameter logic [COEF_N*COEF_B_W-1:0] COEF_B = '0
) (
   input  logic                      clk,
   input  logic                      ena,
   input  logic                      aclr_in,
   input  logic                      aclr_out,
   input  logic [AX_W-1:0]           ax,
   input  logic [AY_W-1:0]           ay,
   input  logic [AZ_W-1:0]           az,
   input  logic [BX_W-1:0]           bx,
   input  logic [BY_W-1:0]           by,
   input  logic [BZ_W-1:0]           bz,
   input  logic                      sub,
   input  logic [$clog2(COEF_N)-1:0] coefsela,
   input  logic [$clog2(COEF_N)-1:0] coefselb,
   output logic [RA_W-1:0]           resulta,
   output logic [RB_W-1:0]           resultb
);

   localparam int  SEL_W   = $clog2(COEF_N);
   localparam bit  IS_WIDE = (MODE == DMP_WIDE);
   localparam int  TOP_XF  = IS_WIDE ? WIDE_X : NARROW_X;
   localparam int  TOP_YF  = IS_WIDE ? WIDE_Y : (AY_SIGNED ? NARROW_YS : NARROW_YU);
   localparam int  TOP_PF  = IS_WIDE ? WIDE_PRE : NARROW_PRE;
   localparam int  BOT_YF  = BY_SIGNED ? NARROW_YS : NARROW_YU;
   localparam int  MIN_RA  = IS_WIDE ? 2 * WIDE_X : 2 * NARROW_YS + 1;

   initial begin
      if (MODE == DMP_PLUS36 && PRE_EN) $error("dual_mult_preadd: no pre-adder with the 36-bit addend");
      if (MODE == DMP_PLUS36 && BY_SIGNED) $error("dual_mult_preadd: addend low half must be unsigned");
      if (MODE == DMP_PLUS36 && (BX_W < ADDEND_HALF || BY_W < ADDEND_HALF))
         $error("dual_mult_preadd: addend halves need 18 bits each");
      if (RA_W < MIN_RA) $error("dual_mult_preadd: resulta too narrow for the mode");
      if (MODE == DMP_DUAL && RB_W < 1) $error("dual_mult_preadd: resultb needed in dual mode");
   end

   // ---------------- input rank ----------------
   logic [AX_W-1:0]  ax_q;
   logic [AY_W-1:0]  ay_q;
   logic [AZ_W-1:0]  az_q;
   logic [BX_W-1:0]  bx_q;
   logic [BY_W-1:0]  by_q;
   logic [BZ_W-1:0]  bz_q;
   logic             sub_q;
   logic [SEL_W-1:0] sela_q;
   logic [SEL_W-1:0] selb_q;

   dmp_reg #(.W(AY_W)) u_in_ay  (.clk(clk), .clr(aclr_in), .en(ena), .d(ay),  .q(ay_q));
   dmp_reg #(.W(BY_W)) u_in_by  (.clk(clk), .clr(aclr_in), .en(ena), .d(by),  .q(by_q));
   dmp_reg #(.W(1))    u_in_sub (.clk(clk), .clr(aclr_in), .en(ena), .d(sub), .q(sub_q));

   generate
      if (COEF_EN) begin : g_in_coef
         // x data registers bypassed, selects registered instead
         assign ax_q = '0;
         assign bx_q = '0;
         dmp_reg #(.W(SEL_W)) u_in_sela (.clk(clk), .clr(aclr_in), .en(ena), .d(coefsela), .q(sela_q));
         dmp_reg #(.W(SEL_W)) u_in_selb (.clk(clk), .clr(aclr_in), .en(ena), .d(coefselb), .q(selb_q));
         logic unused_xin;
         assign unused_xin = ^{ax, bx};
      end else begin : g_in_data
         dmp_reg #(.W(AX_W)) u_in_ax (.clk(clk), .clr(aclr_in), .en(ena), .d(ax), .q(ax_q));
         dmp_reg #(.W(BX_W)) u_in_bx (.clk(clk), .clr(aclr_in), .en(ena), .d(bx), .q(bx_q));
         assign sela_q = '0;
         assign selb_q = '0;
         logic unused_sel;
         assign unused_sel = ^{coefsela, coefselb};
      end

      if (PRE_EN) begin : g_in_pre
         dmp_reg #(.W(AZ_W)) u_in_az (.clk(clk), .clr(aclr_in), .en(ena), .d(az), .q(az_q));
         dmp_reg #(.W(BZ_W)) u_in_bz (.clk(clk), .clr(aclr_in), .en(ena), .d(bz), .q(bz_q));
      end else begin : g_in_nopre
         assign az_q = '0;
         assign bz_q = '0;
         logic unused_zin;
         assign unused_zin = ^{az, bz};
      end
   endgenerate

   // ---------------- multipliers ----------------
   logic signed [PROD_W-1:0] top_x, top_y, top_prod;
   logic signed [PROD_W-1:0] bot_x, bot_y, bot_prod;

   dmp_lane #(
      .X_W(AX_W), .Y_W(AY_W), .Z_W(AZ_W),
      .XF(TOP_XF), .YF(TOP_YF), .PF(TOP_PF),
      .X_SIGNED(AX_SIGNED), .Y_SIGNED(AY_SIGNED),
      .PRE_EN(PRE_EN), .PRE_SUB(PRE_SUB),
      .COEF_EN(COEF_EN), .COEF_N(COEF_N), .COEF_W(COEF_A_W), .COEF(COEF_A)
   ) u_top (
      .x_q(ax_q), .y_q(ay_q), .z_q(az_q), .sel_q(sela_q),
      .x_eff(top_x), .y_eff(top_y), .prod(top_prod)
   );

   dmp_lane #(
      .X_W(BX_W), .Y_W(BY_W), .Z_W(BZ_W),
      .XF(NARROW_X), .YF(BOT_YF), .PF(NARROW_PRE),
      .X_SIGNED(BX_SIGNED), .Y_SIGNED(BY_SIGNED),
      .PRE_EN(PRE_EN && MODE != DMP_PLUS36), .PRE_SUB(PRE_SUB),
      .COEF_EN(COEF_EN), .COEF_N(COEF_N), .COEF_W(COEF_B_W), .COEF(COEF_B)
   ) u_bot (
      .x_q(bx_q), .y_q(by_q), .z_q(bz_q), .sel_q(selb_q),
      .x_eff(bot_x), .y_eff(bot_y), .prod(bot_prod)
   );

   // ---------------- combine and output rank ----------------
   logic [RA_W-1:0] res_a_d;
   logic [RB_W-1:0] res_b_d;

   dmp_combine #(
      .MODE(MODE), .RA_W(RA_W), .RB_W(RB_W), .BX_SIGNED(BX_SIGNED)
   ) u_comb (
      .prod_a(top_prod), .prod_b(bot_prod), .sub_q(sub_q),
      .addend_hi(bx_q[ADDEND_HALF-1:0]), .addend_lo(by_q[ADDEND_HALF-1:0]),
      .res_a_d(res_a_d), .res_b_d(res_b_d)
   );

   dmp_reg #(.W(RA_W)) u_out_a (.clk(clk), .clr(aclr_out), .en(ena), .d(res_a_d), .q(resulta));
   dmp_reg #(.W(RB_W)) u_out_b (.clk(clk), .clr(aclr_out), .en(ena), .d(res_b_d), .q(resultb));

   logic [RB_W-1:0] bot_low;
   assign bot_low = bot_prod[RB_W-1:0];

   logic unused_top;
   assign unused_top = ^{top_x, top_y, bot_x, bot_y, bot_low};

   // ---------------- assertions ----------------
   generate
      if (COEF_EN) begin : g_chk_coef
         // R7: x operand depends only on the select, not on ax
         a_r7_coef_by_select: assert property (@(posedge clk) disable iff (aclr_in || aclr_out)
            $stable(sela_q) |-> $stable(top_x));
      end
      if (MODE == DMP_DUAL) begin : g_chk_dual
         // R1: resultb carries the bottom product one enabled edge later
         a_r1_resultb_follows: assert property (@(posedge clk) disable iff (aclr_in || aclr_out)
            ena |=> (resultb == $past(bot_low)));
      end
   endgenerate

endmodule

// File: tb/tb_dual_mult_preadd.sv
module tb_dual_mult_preadd;
   import dmp_pkg::*;

   localparam int NDUT = 6;

   typedef struct packed {
      logic [26:0] ax;
      logic [26:0] ay;
      logic [25:0] az;
      logic [17:0] bx;
      logic [18:0] by;
      logic [17:0] bz;
      logic        sub;
      logic [2:0]  sa;
      logic [2:0]  sb;
   } vec_t;

   typedef struct packed {
      logic [63:0] a;
      logic [36:0] b;
   } res_t;

   typedef struct packed {
      logic [1:0] mode;
      bit axs, ays, bxs, bys, pre, psub, coef;
   } cfg_t;

   function automatic logic [8*27-1:0] gen_ca();
      logic [8*27-1:0] r;
      for (int i = 0; i < 8; i++) begin
         r[i*27 +: 27] = 27'(i * 32'h0123457 + 32'h13579B);
         if (i[0]) r[i*27 + 17] = 1'b1;
      end
      return r;
   endfunction

   function automatic logic [8*18-1:0] gen_cb();
      logic [8*18-1:0] r;
      for (int i = 0; i < 8; i++) begin
         r[i*18 +: 18] = 18'(i * 32'h0B3C5 + 32'h2A7);
         if (i > 4) r[i*18 + 17] = 1'b1;
      end
      return r;
   endfunction

   localparam logic [8*27-1:0] CA = gen_ca();
   localparam logic [8*18-1:0] CB = gen_cb();

   // configurations of the six instances, in instance order
   function automatic cfg_t get_cfg(int k);
      cfg_t c;
      c = '0;
      case (k)
         0: begin c.mode = 2'd0; c.axs = 1; c.ays = 1; end
         1: begin c.mode = 2'd1; c.axs = 1; c.ays = 1; c.bxs = 1; c.bys = 1; c.pre = 1; end
         2: begin c.mode = 2'd2; c.ays = 1; c.bxs = 1; end
         3: begin c.mode = 2'd3; c.axs = 1; c.ays = 1; c.pre = 1; c.psub = 1; end
         4: begin c.mode = 2'd1; c.axs = 1; c.bxs = 1; c.bys = 1; c.coef = 1; end
         default: begin c.mode = 2'd3; end
      endcase
      return c;
   endfunction

   function automatic string dut_tag(int k);
      case (k)
         0: return "R1 R5";
         1: return "R2 R6";
         2: return "R3";
         3: return "R4 R6";
         4: return "R7 R2";
         default: return "R4 R5";
      endcase
   endfunction

   function automatic longint ext(longint v, int w, bit s);
      longint m;
      longint r;
      m = (longint'(1) <<< w) - 1;
      r = v & m;
      if (s && r[w-1]) r = r | ~m;
      return r;
   endfunction

   function automatic res_t model(cfg_t c, vec_t v);
      res_t   r;
      bit     wide;
      longint xa, ya, xb, yb, pa, pb, acc;
      int     pf;
      wide = (c.mode == 2'd3);
      xa = c.coef ? longint'(CA[32'(v.sa)*27 +: 27]) : longint'(v.ax);
      xa = ext(xa, wide ? 27 : 18, c.axs);
      if (c.pre) begin
         pf = wide ? 26 : 18;
         ya = c.psub ? ext(longint'(v.ay), pf, c.ays) - ext(longint'(v.az), pf, c.ays)
                     : ext(longint'(v.ay), pf, c.ays) + ext(longint'(v.az), pf, c.ays);
      end else begin
         ya = ext(longint'(v.ay), wide ? 27 : (c.ays ? 19 : 18), c.ays);
      end
      xb = c.coef ? longint'(CB[32'(v.sb)*18 +: 18]) : longint'(v.bx);
      xb = ext(xb, 18, c.bxs);
      if (c.pre && c.mode != 2'd2)
         yb = c.psub ? ext(longint'(v.by), 18, c.bys) - ext(longint'(v.bz), 18, c.bys)
                     : ext(longint'(v.by), 18, c.bys) + ext(longint'(v.bz), 18, c.bys);
      else
         yb = ext(longint'(v.by), c.bys ? 19 : 18, c.bys);
      pa = xa * ya;
      pb = xb * yb;
      case (c.mode)
         2'd0: acc = pa;
         2'd1: acc = v.sub ? pb - pa : pb + pa;
         2'd2: acc = pa + ext(longint'({v.bx, v.by[17:0]}), 36, c.bxs);
         default: acc = pa;
      endcase
      r.a = 64'(acc);
      r.b = (c.mode == 2'd0) ? 37'(pb) : 37'd0;
      return r;
   endfunction

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic ena, aclr_in, aclr_out;
   vec_t v;
   logic [63:0] ra [NDUT];
   logic [36:0] rb [NDUT];

   dual_mult_preadd #(.MODE(DMP_DUAL), .AX_SIGNED(1'b1), .AY_SIGNED(1'b1),
      .BX_SIGNED(1'b0), .BY_SIGNED(1'b0)) dut (
      .clk(clk), .ena(ena), .aclr_in(aclr_in), .aclr_out(aclr_out),
      .ax(v.ax), .ay(v.ay), .az(v.az), .bx(v.bx), .by(v.by), .bz(v.bz), .sub(v.sub),
      .coefsela(v.sa), .coefselb(v.sb), .resulta(ra[0]), .resultb(rb[0]));

   dual_mult_preadd #(.MODE(DMP_SUM2), .PRE_EN(1'b1), .PRE_SUB(1'b0)) dut_sum (
      .clk(clk), .ena(ena), .aclr_in(aclr_in), .aclr_out(aclr_out),
      .ax(v.ax), .ay(v.ay), .az(v.az), .bx(v.bx), .by(v.by), .bz(v.bz), .sub(v.sub),
      .coefsela(v.sa), .coefselb(v.sb), .resulta(ra[1]), .resultb(rb[1]));

   dual_mult_preadd #(.MODE(DMP_PLUS36), .AX_SIGNED(1'b0), .AY_SIGNED(1'b1),
      .BX_SIGNED(1'b1), .BY_SIGNED(1'b0)) dut_p36 (
      .clk(clk), .ena(ena), .aclr_in(aclr_in), .aclr_out(aclr_out),
      .ax(v.ax), .ay(v.ay), .az(v.az), .bx(v.bx), .by(v.by), .bz(v.bz), .sub(v.sub),
      .coefsela(v.sa), .coefselb(v.sb), .resulta(ra[2]), .resultb(rb[2]));

   dual_mult_preadd #(.MODE(DMP_WIDE), .PRE_EN(1'b1), .PRE_SUB(1'b1)) dut_wide (
      .clk(clk), .ena(ena), .aclr_in(aclr_in), .aclr_out(aclr_out),
      .ax(v.ax), .ay(v.ay), .az(v.az), .bx(v.bx), .by(v.by), .bz(v.bz), .sub(v.sub),
      .coefsela(v.sa), .coefselb(v.sb), .resulta(ra[3]), .resultb(rb[3]));

   dual_mult_preadd #(.MODE(DMP_SUM2), .AX_SIGNED(1'b1), .AY_SIGNED(1'b0),
      .COEF_EN(1'b1), .COEF_A(CA), .COEF_B(CB)) dut_coef (
      .clk(clk), .ena(ena), .aclr_in(aclr_in), .aclr_out(aclr_out),
      .ax(v.ax), .ay(v.ay), .az(v.az), .bx(v.bx), .by(v.by), .bz(v.bz), .sub(v.sub),
      .coefsela(v.sa), .coefselb(v.sb), .resulta(ra[4]), .resultb(rb[4]));

   dual_mult_preadd #(.MODE(DMP_WIDE), .AX_SIGNED(1'b0), .AY_SIGNED(1'b0)) dut_wu (
      .clk(clk), .ena(ena), .aclr_in(aclr_in), .aclr_out(aclr_out),
      .ax(v.ax), .ay(v.ay), .az(v.az), .bx(v.bx), .by(v.by), .bz(v.bz), .sub(v.sub),
      .coefsela(v.sa), .coefselb(v.sb), .resulta(ra[5]), .resultb(rb[5]));

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   string phase = "reset R10";
   vec_t  in_m;
   res_t  out_m [NDUT];

   task automatic check_all();
      for (int k = 0; k < NDUT; k++) begin
         n_cmp++;
         if (ra[k] !== out_m[k].a) begin
            n_bad++;
            $display("FAIL %s [%s] inst %0d resulta actual=%h expected=%h",
                     dut_tag(k), phase, k, ra[k], out_m[k].a);
         end
         n_cmp++;
         if (rb[k] !== out_m[k].b) begin
            n_bad++;
            $display("FAIL %s [%s] inst %0d resultb actual=%h expected=%h",
                     dut_tag(k), phase, k, rb[k], out_m[k].b);
         end
      end
   endtask

   // one clock: model both ranks at the edge, compare at the falling edge (R8)
   task automatic tick();
      @(posedge clk);
      for (int k = 0; k < NDUT; k++) begin
         if (aclr_out)  out_m[k] = '0;
         else if (ena)  out_m[k] = model(get_cfg(k), in_m);
      end
      if (aclr_in)   in_m = '0;
      else if (ena)  in_m = v;
      @(negedge clk);
      check_all();
   endtask

   function automatic vec_t rand_vec();
      vec_t r;
      r.ax  = 27'($urandom);
      r.ay  = 27'($urandom);
      r.az  = 26'($urandom);
      r.bx  = 18'($urandom);
      r.by  = 19'($urandom);
      r.bz  = 18'($urandom);
      r.sub = 1'($urandom);
      r.sa  = 3'($urandom);
      r.sb  = 3'($urandom);
      return r;
   endfunction

   function automatic vec_t dir_vec(int i);
      vec_t r;
      r = '0;
      case (i)
         0: r = '1;                                           // all ones
         1: begin r.ax = 27'h0020000; r.ay = 27'h0040000;     // narrow minimum codes (R5)
                  r.bx = 18'h20000;   r.by = 19'h40000; r.sub = 1'b1; end
         2: begin r.ax = 27'h4000000; r.ay = 27'h4000000;     // wide minimum codes
                  r.az = 26'h2000000; r.sub = 1'b1; end
         3: begin r.ax = 27'h001FFFF; r.ay = 27'h003FFFF;     // narrow maximum positive
                  r.bx = 18'h1FFFF;   r.by = 19'h7FFFF; r.az = 26'h3FFFFFF; end
         4: begin r.ax = 27'h7FFFFFF; r.ay = 27'h0000001;     // 36-bit addend all ones
                  r.bx = 18'h3FFFF;   r.by = 19'h3FFFF; r.sa = 3'd7; r.sb = 3'd0; end
         5: begin r.ax = 27'h3FFFFFF; r.ay = 27'h3FFFFFF; r.bz = 18'h3FFFF;
                  r.bx = 18'h00005;   r.by = 19'h00003; r.sa = 3'd3; r.sb = 3'd6; end
         default: r = '0;
      endcase
      return r;
   endfunction

   initial begin
      void'($urandom(32'd20240607));
      ena = 1'b1; aclr_in = 1'b0; aclr_out = 1'b0; v = '0;
      in_m = '0;
      for (int k = 0; k < NDUT; k++) out_m[k] = '0;
      #1;
      aclr_in = 1'b1; aclr_out = 1'b1;
      repeat (3) @(negedge clk);
      phase = "reset R10";
      check_all();
      aclr_in = 1'b0; aclr_out = 1'b0;

      // directed corners, one per cycle (R1 R3 R4 R5 R6 R7 R8)
      phase = "directed R5 R8";
      for (int i = 0; i < 6; i++) begin
         v = dir_vec(i);
         tick();
      end
      // same data, sub flipped (R2)
      phase = "sub flip R2";
      v = dir_vec(5); v.sub = 1'b0; tick();
      v.sub = 1'b1; tick();
      // ax changes with a fixed select (R7), bottom inputs change in wide mode (R4)
      phase = "ignored inputs R7 R4";
      for (int i = 0; i < 4; i++) begin
         v.ax = 27'($urandom); v.bx = 18'($urandom); v.by = 19'($urandom); v.bz = 18'($urandom);
         tick();
      end

      // stall (R9)
      phase = "stall R9";
      v = rand_vec(); tick();
      ena = 1'b0;
      for (int i = 0; i < 3; i++) begin v = rand_vec(); tick(); end
      ena = 1'b1;
      v = rand_vec(); tick(); tick();

      // asynchronous clears (R10)
      phase = "clear R10";
      v = rand_vec(); tick(); tick();
      aclr_out = 1'b1;
      #1;
      for (int k = 0; k < NDUT; k++) out_m[k] = '0;
      check_all();
      tick();
      aclr_out = 1'b0;
      v = rand_vec(); tick();
      aclr_in = 1'b1;
      #1;
      in_m = '0;
      tick();
      aclr_in = 1'b0;
      v = rand_vec(); tick(); tick(); tick();

      // random stream with random stalls (R8 R9)
      phase = "random R8 R9";
      for (int i = 0; i < 600; i++) begin
         v   = rand_vec();
         ena = (($urandom % 8) != 0);
         tick();
      end
      ena = 1'b1;
      tick(); tick();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule